// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block carries out one memory or I/O transfer at a time on a bus where the low address bits and the data share the same lines. A requester presents an address, a read/write flag, an I/O flag and write data. The block then runs a cycle of at least four clock states, T1 through T4. In T1 it puts the address on the shared lines and pulses the address latch enable. From T2 to T4 it drives the read or write strobe, the transceiver enable and the transfer direction. When the addressed device holds ready low, it adds wait states (Tw) between T3 and T4. Read data is returned together with a one-cycle done pulse.

A second bus master can take the bus with a hold request. The block samples the request on every rising edge. It lets any cycle already in progress finish, then raises hold acknowledge and releases every address, data and control output by dropping their output enables. It takes no new requests while the bus is released. When the hold request falls, acknowledge drops on the next falling clock edge, and the block drives the bus again from the following rising edge.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle. `ale`=0, `rdN`=1, `wrN`=1, `denN`=1, `ioM`=0, `hlda`=0, `rspDone`=0 and `reqReady`=1.
- R2: `ale` is high for exactly one cycle, T1, the cycle after a request is accepted. In T1, `adOut` carries address bits [DATA_W-1:0] with `adOe`=1, and `addrHi` carries the upper address bits for the whole cycle.
- R3: When `ready` is high at the end of T3, the cycle takes exactly four states. `rspDone` is high in the fourth cycle after the acceptance edge, and the block is idle in the fifth.
- R4: Each low sample of `ready`, taken at the end of T3 or of a Tw, inserts exactly one wait state before T4.
- R5: For a read (`reqWrite`=0), `rdN` is low from T2 through T4, including any Tw. For a write, `wrN` is low over the same states. The two strobes are never low together.
- R6: `ioM` is 1 from T1 to T4 for an I/O access (`reqIo`=1), 0 for a memory access, and 0 when idle.
- R7: `denN` is low from T2 to T4 and high otherwise. `dtR` is 1 for a write and 0 for a read from T1 to T4.
- R8: For a write, `adOut` carries the write data with `adOe`=1 from T2 to T4. For a read, `adOe` is 0 after T1.
- R9: For a read, the value on `adIn` at the edge that enters T4 appears on `rspRdata` while `rspDone` is high. `rspDone` is a single-cycle pulse.
- R10: When `hold` rises during a cycle, `hlda` stays 0 until the edge that ends T4, and rises on that edge.
- R11: When `hold` is high while idle, `hlda` rises on the next rising edge, and `reqReady` stays 0, so no cycle starts (`ale` stays 0).
- R12: While `hlda` is high, `adOe`=0 and `busOe`=0.
- R13: After `hold` falls, `hlda` falls on the next falling clock edge. `busOe` and `reqReady` return to 1 after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory |
| reqAddr | input | ADDR_W | Transfer address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| rspDone | output | 1 | One-cycle completion pulse (T4) |
| rspRdata | output | DATA_W | Captured read data |
| adOut | output | DATA_W | Shared address/data lines, driven value |
| adOe | output | 1 | Output enable for adOut |
| adIn | input | DATA_W | Shared address/data lines, received value |
| addrHi | output | ADDR_W-DATA_W | Upper address bits |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | 1 = I/O access, 0 = memory access |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | Transceiver direction, 1 = outbound |
| busOe | output | 1 | Output enable for addrHi and control outputs |
| ready | input | 1 | Device ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
Some rules are checked on every cycle: the two strobes are never low together, the address latch enable is a single-cycle pulse, done is a single-cycle pulse, and the transceiver enable is active only together with a strobe. Also on every cycle, every enable is off while acknowledge is high, and acknowledge rises only after a sampled hold request. Other behaviour needs the bench's scenarios. These are the exact cycle lengths for each wait-state count, the values on the shared lines in each state, the read data captured at the T4 entry edge, acknowledge held back until the end of T4, and acknowledge dropping on the falling edge before the bus is driven again.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } busState_e;

  // Phase strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // latch a new request
    logic capture;    // sample the shared lines (read data)
    logic addrPhase;  // T1
    logic cmdPhase;   // T2, T3, Tw, T4
    logic active;     // T1 .. T4
  } dpStrobe_t;

endpackage

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      ready,
  input  logic      hold,
  output dpStrobe_t strb,
  output logic      reqReady,
  output logic      rspDone,
  output logic      ale,
  output logic      busOe,
  output logic      hlda
);

  busState_e state, nextState;
  logic holdNeg;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (hold)          nextState = ST_HOLD;
        else if (reqValid) nextState = ST_T1;
      end
      ST_T1:   nextState = ST_T2;
      ST_T2:   nextState = ST_T3;
      ST_T3:   nextState = ready ? ST_T4 : ST_TW;
      ST_TW:   nextState = ready ? ST_T4 : ST_TW;
      ST_T4:   nextState = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: nextState = hold ? ST_HOLD : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // Released on the falling edge after hold is seen low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) holdNeg <= 1'b0;
    else       holdNeg <= hold;
  end

  always_comb begin
    reqReady      = (state == ST_IDLE) && !hold;
    strb.load     = reqReady && reqValid;
    strb.capture  = ((state == ST_T3) || (state == ST_TW)) && ready;
    strb.addrPhase = (state == ST_T1);
    strb.cmdPhase = (state == ST_T2) || (state == ST_T3) ||
                    (state == ST_TW) || (state == ST_T4);
    strb.active   = strb.addrPhase || strb.cmdPhase;
    rspDone       = (state == ST_T4);
    ale           = strb.addrPhase;
    busOe         = (state != ST_HOLD);
    hlda          = (state == ST_HOLD) && holdNeg;
  end

endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strb,
  input  logic                     reqWrite,
  input  logic                     reqIo,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     denN,
  output logic                     dtR,
  output logic [DATA_W-1:0]        rspRdata
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] wdataR;
  logic [DATA_W-1:0] rdataR;
  logic              writeR;
  logic              ioR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      wdataR <= '0;
      writeR <= 1'b0;
      ioR    <= 1'b0;
    end else if (strb.load) begin
      addrR  <= reqAddr;
      wdataR <= reqWdata;
      writeR <= reqWrite;
      ioR    <= reqIo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       rdataR <= '0;
    else if (strb.capture && !writeR) rdataR <= adIn;
  end

  always_comb begin
    if (strb.addrPhase)                   adOut = addrR[DATA_W-1:0];
    else if (strb.cmdPhase && writeR)     adOut = wdataR;
    else                                  adOut = '0;
    adOe     = strb.addrPhase || (strb.cmdPhase && writeR);
    addrHi   = strb.active ? addrR[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
    rdN      = !(strb.cmdPhase && !writeR);
    wrN      = !(strb.cmdPhase && writeR);
    ioM      = strb.active && ioR;
    denN     = !strb.cmdPhase;
    dtR      = strb.active && writeR;
    rspRdata = rdataR;
  end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqIo,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     reqReady,
  output logic                     rspDone,
  output logic [DATA_W-1:0]        rspRdata,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     denN,
  output logic                     dtR,
  output logic                     busOe,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda
);

  dpStrobe_t strb;

  mbc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ready    (ready),
    .hold     (hold),
    .strb     (strb),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .ale      (ale),
    .busOe    (busOe),
    .hlda     (hlda)
  );

  mbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqIo    (reqIo),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .addrHi   (addrHi),
    .rdN      (rdN),
    .wrN      (wrN),
    .ioM      (ioM),
    .denN     (denN),
    .dtR      (dtR),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic adOe,
  input logic rdN,
  input logic wrN,
  input logic denN,
  input logic busOe,
  input logic hlda,
  input logic hold,
  input logic rspDone
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R12
  hold_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (!adOe && !busOe));

  // R10
  hlda_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hlda) |-> $past(hold));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R7
  den_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !denN |-> (!rdN || !wrN));

endmodule

bind mbus_cycle_ctrl mbc_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ale     (ale),
  .adOe    (adOe),
  .rdN     (rdN),
  .wrN     (wrN),
  .denN    (denN),
  .busOe   (busOe),
  .hlda    (hlda),
  .hold    (hold),
  .rspDone (rspDone)
);

// File: tb/mbus_cycle_ctrl_tb_top.sv
module mbus_cycle_ctrl_tb_top;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspDone;
  logic [DW-1:0] rspRdata, adOut;
  logic          adOe;
  logic [DW-1:0] adIn = '0;
  logic [AW-DW-1:0] addrHi;
  logic          ale, rdN, wrN, ioM, denN, dtR, busOe, hlda;
  logic          ready = 1'b1, hold = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIo(reqIo), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspDone(rspDone), .rspRdata(rspRdata),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .addrHi(addrHi), .ale(ale),
    .rdN(rdN), .wrN(wrN), .ioM(ioM), .denN(denN), .dtR(dtR),
    .busOe(busOe), .ready(ready), .hold(hold), .hlda(hlda)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Strobe levels expected during T2..T4
  task automatic chkCmd(input bit wr, input bit io, input logic [DW-1:0] wd);
    chk("R5", "rdN", rdN, wr);
    chk("R5", "wrN", wrN, !wr);
    chk("R7", "denN", denN, 1'b0);
    chk("R7", "dtR", dtR, wr);
    chk("R6", "ioM", ioM, io);
    chk("R2", "ale", ale, 1'b0);
    chk("R8", "adOe", adOe, wr);
    if (wr) chk("R8", "adOut", adOut, wd);
  endtask

  task automatic xfer(input bit wr, input bit io, input int waits,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] rd, input bit holdMid);
    tick();
    reqValid = 1'b1; reqWrite = wr; reqIo = io; reqAddr = a; reqWdata = wd;
    chk("R11", "reqReady idle", reqReady, 1'b1);
    tick();                                   // T1
    reqValid = 1'b0; reqWdata = ~wd; reqAddr = ~a;
    chk("R2", "ale T1", ale, 1'b1);
    chk("R2", "adOe T1", adOe, 1'b1);
    chk("R2", "adOut addr", adOut, a[DW-1:0]);
    chk("R2", "addrHi", addrHi, a[AW-1:DW]);
    chk("R6", "ioM T1", ioM, io);
    chk("R7", "dtR T1", dtR, wr);
    chk("R7", "denN T1", denN, 1'b1);
    chk("R5", "strobes T1", {rdN, wrN}, 2'b11);
    adIn = rd;
    tick();                                   // T2
    chkCmd(wr, io, wd);
    chk("R2", "addrHi T2", addrHi, a[AW-1:DW]);
    if (holdMid) hold = 1'b1;
    tick();                                   // T3
    chkCmd(wr, io, wd);
    chk("R3", "done T3", rspDone, 1'b0);
    if (holdMid) chk("R10", "hlda T3", hlda, 1'b0);
    ready = (waits == 0);
    for (int k = 1; k <= waits; k++) begin
      tick();                                 // Tw
      chkCmd(wr, io, wd);
      chk("R4", "done in Tw", rspDone, 1'b0);
      if (holdMid) chk("R10", "hlda Tw", hlda, 1'b0);
      ready = (k == waits);
    end
    tick();                                   // T4
    ready = 1'b1;
    chk("R3", "done T4", rspDone, 1'b1);
    chkCmd(wr, io, wd);
    if (!wr) chk("R9", "rdata", rspRdata, rd);
    if (holdMid) chk("R10", "hlda T4", hlda, 1'b0);
    adIn = ~rd;
    tick();
    chk("R9", "done pulse", rspDone, 1'b0);
    chk("R5", "strobes off", {rdN, wrN}, 2'b11);
    chk("R7", "denN off", denN, 1'b1);
    chk("R6", "ioM off", ioM, 1'b0);
    if (!wr) chk("R9", "rdata held", rspRdata, rd);
    if (holdMid) begin
      chk("R10", "hlda after T4", hlda, 1'b1);
      chk("R12", "adOe held", adOe, 1'b0);
      chk("R12", "busOe held", busOe, 1'b0);
      chk("R11", "reqReady held", reqReady, 1'b0);
    end else begin
      chk("R3", "reqReady back", reqReady, 1'b1);
      chk("R3", "ale idle", ale, 1'b0);
    end
  endtask

  task automatic releaseHold();
    hold = 1'b0;
    chk("R13", "hlda before fall", hlda, 1'b1);
    #4;                                       // past falling edge
    chk("R13", "hlda after fall", hlda, 1'b0);
    chk("R13", "busOe still off", busOe, 1'b0);
    @(posedge clk); #1;
    chk("R13", "busOe back", busOe, 1'b1);
    chk("R13", "reqReady back", reqReady, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #10;
    chk("R1", "ale", ale, 1'b0);
    chk("R1", "strobes", {rdN, wrN, denN}, 3'b111);
    chk("R1", "ioM", ioM, 1'b0);
    chk("R1", "hlda", hlda, 1'b0);
    chk("R1", "done", rspDone, 1'b0);
    rstN = 1'b1;
    tick();
    chk("R1", "reqReady", reqReady, 1'b1);

    // Sweep: direction x space x wait count
    for (int w = 0; w < 4; w++)
      for (int io = 0; io < 2; io++)
        for (int wr = 0; wr < 2; wr++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] wd, rd;
          a  = AW'(32'h5A3C1 + w * 32'h11111 + io * 32'h8421 + wr * 32'h30303);
          wd = DW'(16'hC001 ^ (w * 16'h0F0F) ^ (io * 16'h1234) ^ wr);
          rd = DW'(16'h9E37 + w * 16'h0101 + io * 16'h2222 + wr * 16'h4444);
          xfer(wr[0], io[0], w, a, wd, rd, 1'b0);
        end

    // R10: hold raised mid-cycle, acknowledged only after T4
    xfer(1'b0, 1'b0, 1, 20'hABCDE, 16'h0, 16'h7E57, 1'b1);
    tick();
    chk("R12", "hlda stays", hlda, 1'b1);
    chk("R12", "busOe off", busOe, 1'b0);
    releaseHold();

    // R11: hold while idle, requests blocked
    hold = 1'b1;
    tick();
    chk("R11", "hlda from idle", hlda, 1'b1);
    reqValid = 1'b1; reqAddr = 20'h12345;
    for (int k = 0; k < 3; k++) begin
      chk("R11", "reqReady blocked", reqReady, 1'b0);
      tick();
      chk("R11", "no ale", ale, 1'b0);
      chk("R12", "adOe off", adOe, 1'b0);
    end
    reqValid = 1'b0;
    releaseHold();
    xfer(1'b1, 1'b1, 2, 20'h0F00F, 16'hBEEF, 16'h0, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule